// File: doc/BRIEF.md
# Bus Master Transaction Sequencer

This block is the requesting side of a shared bus where several agents compete for ownership through a request/grant handshake with an arbiter. Each time it is started, it runs one fixed transaction. It requests the bus and drives an address phase. It then waits for a read-data flag and drives a write-data phase before going back to idle. While doing this it watches the slave's ready line and a two-bit response code. The response code can stall the sequence, roll it back by one phase, freeze it or abort it.

The arbiter can mask the master after a split response. While masked, the sequencer freezes. A grant that arrives during the mask is a protocol violation. Any violation, including an ERROR response or an input pattern that none of the transition rules covers, sends the block into a trap state. Only reset clears the trap state. The block tells the arbiter which phase it is in through a two-bit code.

Address and data are single-bit markers here, not real buses. Reset is asynchronous and active-low. Its release is synchronized to the clock through a short flop chain.

Top module: `bus_seq_master`

## Requirements
- R1: While reset is applied, and for the cycles after release until the release has passed the synchronizer, every output is zero: no request, transfer type IDLE, arbiter phase idle.
- R2: From idle, the block moves to the request phase on the clock edge after `start_i` is high, provided ready is high, the response is OK and there is no mask. With `start_i` low it stays idle.
- R3: In the request phase `busreq_o` is high. The block stays there while grant is low. When grant is high with response OK (code 2'b00), it moves to the address phase.
- R4: With grant high and response OK, the address phase moves to read. Read moves to write only when `rdata_i` is also high. Write then returns to idle.
- R5: A response of ERROR (code 2'b01) sends the block to the error state on the next edge, whatever phase it is in.
- R6: Grant high while `mask_i` is high sends the block to the error state.
- R7: Grant high with response RETRY (code 2'b10) sets the phase to the one the block held in the previous cycle.
- R8: The phase is held in three cases: grant with response SPLIT (code 2'b11), ready low, or mask high without grant.
- R9: Transfer type is NONSEQ (2'b10) in the address, read and write phases and IDLE (2'b00) otherwise. `addr_vld_o` is high only in the address phase, `wdata_o` only in the write phase, and `busreq_o` only in the request phase.
- R10: `arb_phase_o` is 2'b01 for address, 2'b10 for read and 2'b11 for write. It is 2'b00 for idle, request and error.
- R11: The error state is kept until reset. A start strobe or any other input while in error does not raise `busreq_o`.
- R12: A combination that no rule covers goes to error. Examples are read with grant and OK but `rdata_i` low, or the address phase without grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a transaction from idle |
| grant_i | input | 1 | Bus granted by the arbiter |
| ready_i | input | 1 | Slave ready; low stalls the sequence |
| resp_i | input | 2 | Response: 00 OK, 01 ERROR, 10 RETRY, 11 SPLIT |
| rdata_i | input | 1 | Read data returned |
| mask_i | input | 1 | Master masked by the arbiter after a split |
| busreq_o | output | 1 | Bus request |
| htrans_o | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ |
| addr_vld_o | output | 1 | Address phase marker |
| wdata_o | output | 1 | Write data phase marker |
| arb_phase_o | output | 2 | Phase code for the arbiter |

## Verification
Every output is decoded from the current phase register alone, so a wrong next phase is visible at the ports in the cycle right after the faulty edge. The one exception is that idle, request-free idle and error look the same at the ports. The difference shows only in the following cycle, when a start strobe either raises `busreq_o` or does not. The previous-phase register is not visible at the ports until a RETRY arrives, and a fault in it then shows as the wrong rolled-back phase. The bench drives a long pseudo-random input stream against a bench-side model of the rules and compares all outputs every cycle. It also walks the directed corner cases.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int STATE_W = 3;
  localparam int CODE_W  = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_READ  = 3'd3,
    ST_WRITE = 3'd4,
    ST_ERR   = 3'd5
  } seq_state_e;

  typedef enum logic [CODE_W-1:0] {
    RSP_OK    = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } resp_e;

  typedef enum logic [CODE_W-1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [CODE_W-1:0] {
    AP_IDLE  = 2'b00,
    AP_ADDR  = 2'b01,
    AP_READ  = 2'b10,
    AP_WRITE = 2'b11
  } arb_phase_e;
endpackage

// File: rtl/bsm_rst_sync.sv
module bsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsm_next.sv
module bsm_next
  import bsm_pkg::*;
(
  input  seq_state_e cur_state,
  input  seq_state_e prev_state,
  input  logic       start,
  input  logic       grant,
  input  logic       ready,
  input  resp_e      resp,
  input  logic       rdata,
  input  logic       mask,
  output seq_state_e nxt_state
);
  logic ok_grant;
  assign ok_grant = grant && (resp == RSP_OK);

  // Ordered by priority; the first matching rule wins.
  always_comb begin
    if (cur_state == ST_ERR)                    nxt_state = ST_ERR;
    else if (resp == RSP_ERROR)                 nxt_state = ST_ERR;
    else if (mask && grant)                     nxt_state = ST_ERR;
    else if (grant && (resp == RSP_SPLIT))      nxt_state = cur_state;
    else if (!ready)                            nxt_state = cur_state;
    else if (mask)                              nxt_state = cur_state;
    else if (grant && (resp == RSP_RETRY))      nxt_state = prev_state;
    else if (cur_state == ST_IDLE)              nxt_state = start ? ST_REQ : ST_IDLE;
    else if (cur_state == ST_REQ && ok_grant)   nxt_state = ST_ADDR;
    else if (cur_state == ST_REQ && !grant)     nxt_state = ST_REQ;
    else if (cur_state == ST_ADDR && ok_grant)  nxt_state = ST_READ;
    else if (cur_state == ST_READ && ok_grant && rdata)
                                                nxt_state = ST_WRITE;
    else if (cur_state == ST_WRITE && ok_grant) nxt_state = ST_IDLE;
    else                                        nxt_state = ST_ERR;
  end
endmodule

// File: rtl/bsm_outdec.sv
module bsm_outdec
  import bsm_pkg::*;
(
  input  seq_state_e        state,
  output logic              busreq,
  output logic [CODE_W-1:0] htrans,
  output logic              addr_vld,
  output logic              wdata,
  output logic [CODE_W-1:0] arb_phase
);
  trans_e     trans_c;
  arb_phase_e phase_c;

  always_comb begin
    busreq   = 1'b0;
    addr_vld = 1'b0;
    wdata    = 1'b0;
    trans_c  = TR_IDLE;
    phase_c  = AP_IDLE;
    unique case (state)
      ST_REQ:   busreq = 1'b1;
      ST_ADDR:  begin addr_vld = 1'b1; trans_c = TR_NONSEQ; phase_c = AP_ADDR;  end
      ST_READ:  begin                  trans_c = TR_NONSEQ; phase_c = AP_READ;  end
      ST_WRITE: begin wdata    = 1'b1; trans_c = TR_NONSEQ; phase_c = AP_WRITE; end
      default:  ;
    endcase
  end

  assign htrans    = trans_c;
  assign arb_phase = phase_c;
endmodule

// File: rtl/bus_seq_master.sv
module bus_seq_master
  import bsm_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              grant_i,
  input  logic              ready_i,
  input  logic [CODE_W-1:0] resp_i,
  input  logic              rdata_i,
  input  logic              mask_i,
  output logic              busreq_o,
  output logic [CODE_W-1:0] htrans_o,
  output logic              addr_vld_o,
  output logic              wdata_o,
  output logic [CODE_W-1:0] arb_phase_o
);
  logic       rst_sync_n;
  seq_state_e state_q, prev_q, state_d;

  bsm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsm_next u_next (
    .cur_state  (state_q),
    .prev_state (prev_q),
    .start      (start_i),
    .grant      (grant_i),
    .ready      (ready_i),
    .resp       (resp_e'(resp_i)),
    .rdata      (rdata_i),
    .mask       (mask_i),
    .nxt_state  (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      prev_q  <= ST_IDLE;
    end else begin
      state_q <= state_d;
      prev_q  <= state_q;
    end
  end

  bsm_outdec u_out (
    .state     (state_q),
    .busreq    (busreq_o),
    .htrans    (htrans_o),
    .addr_vld  (addr_vld_o),
    .wdata     (wdata_o),
    .arb_phase (arb_phase_o)
  );
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker
  import bsm_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              grant_i,
  input logic              ready_i,
  input logic [CODE_W-1:0] resp_i,
  input logic              mask_i,
  input logic              busreq_o,
  input logic [CODE_W-1:0] htrans_o,
  input logic              addr_vld_o,
  input logic              wdata_o,
  input logic [CODE_W-1:0] arb_phase_o,
  input seq_state_e        state,
  input seq_state_e        prev
);
  a_r3_wait_grant: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_REQ && !grant_i && ready_i && !mask_i && resp_i != RSP_ERROR)
      |=> state == ST_REQ);

  a_r5_error_resp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (resp_i == RSP_ERROR) |=> state == ST_ERR);

  a_r6_masked_grant: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_i && grant_i) |=> state == ST_ERR);

  a_r7_retry_rollback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state != ST_ERR && grant_i && ready_i && !mask_i && resp_i == RSP_RETRY)
      |=> state == $past(prev));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ready_i && resp_i != RSP_ERROR && !(mask_i && grant_i)) |=> $stable(state));

  a_r9_one_marker: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |-> $countones({busreq_o, addr_vld_o, wdata_o}) <= 1);

  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (arb_phase_o == AP_IDLE) |-> (htrans_o == TR_IDLE && !addr_vld_o && !wdata_o));

  a_r11_sticky_err: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_ERR) |=> (state == ST_ERR && !busreq_o));
endmodule

bind bus_seq_master bsm_checker u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .grant_i     (grant_i),
  .ready_i     (ready_i),
  .resp_i      (resp_i),
  .mask_i      (mask_i),
  .busreq_o    (busreq_o),
  .htrans_o    (htrans_o),
  .addr_vld_o  (addr_vld_o),
  .wdata_o     (wdata_o),
  .arb_phase_o (arb_phase_o),
  .state       (state_q),
  .prev        (prev_q)
);

// File: tb/tb_bus_seq_master.sv
module tb_bus_seq_master;
  localparam int CLK_PERIOD = 10;
  localparam int M_IDLE = 0, M_REQ = 1, M_ADDR = 2, M_READ = 3, M_WRITE = 4, M_ERR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, grant_i = 1'b0, ready_i = 1'b1, rdata_i = 1'b0, mask_i = 1'b0;
  logic [1:0] resp_i = 2'b00;
  logic busreq_o, addr_vld_o, wdata_o;
  logic [1:0] htrans_o, arb_phase_o;

  int checks = 0;
  int errors = 0;
  int mst = M_IDLE;
  int mprev = M_IDLE;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_seq_master dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .grant_i(grant_i), .ready_i(ready_i),
    .resp_i(resp_i), .rdata_i(rdata_i), .mask_i(mask_i), .busreq_o(busreq_o),
    .htrans_o(htrans_o), .addr_vld_o(addr_vld_o), .wdata_o(wdata_o), .arb_phase_o(arb_phase_o)
  );

  function automatic int model_next(int s, int p, logic st, logic g, logic rd,
                                    logic [1:0] rs, logic dat, logic mk);
    if (s == M_ERR || rs == 2'b01 || (mk && g)) return M_ERR;
    if ((g && rs == 2'b11) || !rd || mk) return s;
    if (g && rs == 2'b10) return p;
    if (s == M_IDLE) return st ? M_REQ : M_IDLE;
    if (s == M_REQ && !g) return M_REQ;
    if (g && rs == 2'b00) begin
      if (s == M_REQ) return M_ADDR;
      if (s == M_ADDR) return M_READ;
      if (s == M_READ && dat) return M_WRITE;
      if (s == M_WRITE) return M_IDLE;
    end
    return M_ERR;
  endfunction

  // {busreq, htrans[1:0], addr_vld, wdata, phase[1:0]}
  function automatic logic [6:0] model_outs(int s);
    logic act;
    act = (s == M_ADDR || s == M_READ || s == M_WRITE);
    return {s == M_REQ, act ? 2'b10 : 2'b00, s == M_ADDR, s == M_WRITE,
            s == M_ADDR ? 2'b01 : s == M_READ ? 2'b10 : s == M_WRITE ? 2'b11 : 2'b00};
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] dut_outs();
    return {busreq_o, htrans_o, addr_vld_o, wdata_o, arb_phase_o};
  endfunction

  task automatic cyc(string tag, logic st, logic g, logic rd, logic [1:0] rs, logic dat, logic mk);
    start_i = st; grant_i = g; ready_i = rd; resp_i = rs; rdata_i = dat; mask_i = mk;
    @(posedge clk);
    begin
      int nx;
      nx = model_next(mst, mprev, st, g, rd, rs, dat, mk);
      mprev = mst;
      mst = nx;
    end
    @(negedge clk);
    chk(tag, dut_outs(), model_outs(mst));
  endtask

  task automatic do_reset();
    start_i = 0; grant_i = 0; ready_i = 1; resp_i = 0; rdata_i = 0; mask_i = 0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 in reset", dut_outs(), 7'b0);
    rst_n = 1'b1;
    mst = M_IDLE; mprev = M_IDLE;
    for (int i = 0; i < 3; i++) cyc("R1 after release", 0, 0, 1, 2'b00, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 idle outputs", dut_outs(), 7'b0);

    // R2: start gating
    cyc("R2 no start", 0, 0, 1, 2'b00, 0, 0);
    cyc("R2 no start", 0, 0, 1, 2'b00, 0, 0);
    chk("R2 stays idle", dut_outs(), 7'b0);
    cyc("R2 start", 1, 0, 1, 2'b00, 0, 0);
    chk("R2 request", dut_outs(), 7'b1_00_0_0_00);
    // R3: wait for grant, then address
    cyc("R3 wait", 0, 0, 1, 2'b00, 0, 0);
    chk("R3 still requesting", dut_outs(), 7'b1_00_0_0_00);
    cyc("R3 grant", 0, 1, 1, 2'b00, 0, 0);
    chk("R3 R9 R10 address", dut_outs(), 7'b0_10_1_0_01);
    // R4 / R7 / R8
    cyc("R4 to read", 0, 1, 1, 2'b00, 0, 0);
    chk("R4 read", dut_outs(), 7'b0_10_0_0_10);
    cyc("R7 retry", 0, 1, 1, 2'b10, 1, 0);
    chk("R7 rolled back to address", dut_outs(), 7'b0_10_1_0_01);
    cyc("R4 read again", 0, 1, 1, 2'b00, 0, 0);
    cyc("R8 split", 0, 1, 1, 2'b11, 1, 0);
    chk("R8 split hold", dut_outs(), 7'b0_10_0_0_10);
    cyc("R8 not ready", 0, 1, 0, 2'b00, 1, 0);
    chk("R8 ready low hold", dut_outs(), 7'b0_10_0_0_10);
    cyc("R8 masked", 0, 0, 1, 2'b00, 1, 1);
    chk("R8 mask hold", dut_outs(), 7'b0_10_0_0_10);
    cyc("R4 to write", 0, 1, 1, 2'b00, 1, 0);
    chk("R4 R9 write", dut_outs(), 7'b0_10_0_1_11);
    cyc("R4 to idle", 0, 1, 1, 2'b00, 0, 0);
    chk("R4 back idle", dut_outs(), 7'b0);
    cyc("R4 restart", 1, 0, 1, 2'b00, 0, 0);
    chk("R4 idle accepts start", dut_outs(), 7'b1_00_0_0_00);

    // R5 and R11
    cyc("R5 grant", 0, 1, 1, 2'b00, 0, 0);
    cyc("R5 error resp", 0, 1, 1, 2'b01, 0, 0);
    chk("R5 error", dut_outs(), 7'b0);
    for (int i = 0; i < 3; i++) begin
      cyc("R11 probe", 1, 0, 1, 2'b00, 0, 0);
      chk("R11 no request in error", {6'b0, busreq_o}, 7'b0);
    end
    do_reset();

    // R6
    cyc("R6 start", 1, 0, 1, 2'b00, 0, 0);
    cyc("R6 masked grant", 0, 1, 1, 2'b00, 0, 1);
    cyc("R6 probe", 1, 0, 1, 2'b00, 0, 0);
    chk("R6 trapped", dut_outs(), 7'b0);
    do_reset();

    // R12
    cyc("R12 start", 1, 0, 1, 2'b00, 0, 0);
    cyc("R12 addr", 0, 1, 1, 2'b00, 0, 0);
    cyc("R12 read", 0, 1, 1, 2'b00, 0, 0);
    cyc("R12 no rdata", 0, 1, 1, 2'b00, 0, 0);
    cyc("R12 probe", 1, 0, 1, 2'b00, 0, 0);
    chk("R12 uncovered read", dut_outs(), 7'b0);
    do_reset();
    cyc("R12 start", 1, 0, 1, 2'b00, 0, 0);
    cyc("R12 addr", 0, 1, 1, 2'b00, 0, 0);
    cyc("R12 addr no grant", 0, 0, 1, 2'b00, 0, 0);
    cyc("R12 probe", 1, 0, 1, 2'b00, 0, 0);
    chk("R12 uncovered address", dut_outs(), 7'b0);
    do_reset();

    // R9 R10 sweep: pseudo-random stream against the model
    begin
      logic [15:0] lf;
      int err_cnt;
      lf = 16'hACE1;
      err_cnt = 0;
      for (int n = 0; n < 6000; n++) begin
        logic [1:0] rs;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rs = (lf[10:8] == 3'b000) ? lf[12:11] : 2'b00;
        cyc("R9 R10 sweep", lf[0] | lf[1], lf[2] | lf[3], lf[4] | lf[5] | lf[6],
            rs, lf[13] | lf[14], lf[15:13] == 3'b111);
        if (mst == M_ERR) err_cnt++;
        if (err_cnt > 2) begin
          err_cnt = 0;
          do_reset();
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule